// File: doc/BRIEF.md
# Time Base and Decrementer Timer

This block is the timer unit that sits beside a processor core. It keeps a 64-bit time base that counts up by one on every cycle in which the timebase tick enable is high. It also keeps a 32-bit decrementer that counts down on the same tick. Software sees both through a small register port: a 2-bit address selects the low time-base word, the high time-base word or the decrementer. A single-cycle write strobe loads the selected register. The read data always shows the selected register.

The decrementer raises its interrupt on a sign change, not on a terminal count. When the count falls below zero it wraps to all ones and the interrupt is raised. A software write that turns a non-negative value into a negative one also raises it. The request is sticky until a clear strobe removes it. A mode input selects a real-time-clock flavour, in which the low time-base word hides bits 31:30 and 6:0 on both read and write. In that mode the tick enable is expected at 7,812,500 Hz. The tick enable is made outside this block.

Top module: `tbdec_timer`

## Requirements
- R1: After reset the time base reads 0 in both words, the decrementer reads 0xFFFFFFFF and irq is low.
- R2: On each cycle with tick_en high, the 64-bit time base adds one, and a carry out of the low word goes into the high word. With tick_en low and no write, it holds.
- R3: A write to address 0 replaces time-base bits 31:0 and keeps bits 63:32. A write to address 1 replaces bits 63:32 and keeps bits 31:0.
- R4: On each tick the decrementer (address 2) decreases by one, unless it is being written.
- R5: A tick with the decrementer at 0x00000000 reloads it with 0xFFFFFFFF and sets irq.
- R6: A write to the decrementer sets irq if the new value has bit 31 set and the current value has bit 31 clear. No other write sets irq.
- R7: irq stays set until irq_clr is high. If a new event and irq_clr occur in the same cycle, irq stays set.
- R8: A write that lands on a tick cycle wins for the register written: the written time-base word takes the write data, the other word keeps its current value and is not incremented. A decrementer write takes no decrement. The register not being written still counts.
- R9: With rtc_mode high, address 0 reads back the time-base low word ANDed with 0x3FFFFF80, and a write to address 0 stores the write data ANDed with 0x3FFFFF80.
- R10: Address 3 reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Timebase tick, one clock wide |
| rtc_mode | input | 1 | Selects the real-time-clock low-word mask |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 2 | 0 time-base low, 1 time-base high, 2 decrementer, 3 unused |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the selected register |
| irq_clr | input | 1 | Clears the pending timer interrupt |
| irq | output | 1 | Pending timer interrupt request |

## Verification
Every register update, whether from a tick or a write, shows on rdata one rising edge after the cycle that carried it, because the read mux is combinational over the state flops. irq is also due one edge after its setting or clearing event. The bench drives inputs on the falling edge and compares at the following falling edge against a cycle-accurate arithmetic model. Reads are made by changing addr within that low phase, so each read shows the state after exactly one edge.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  typedef enum logic [1:0] {
    SEL_TB_LO = 2'd0,
    SEL_TB_HI = 2'd1,
    SEL_DEC   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tbd_timebase.sv
module tbd_timebase #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [2*DW-1:0] tb_q
);
  localparam int TW = 2 * DW;

  logic [TW-1:0] tb_d;
  logic          tb_en;

  // write wins over the tick; the untouched half keeps its present value
  always_comb begin
    tb_d  = tb_q;
    tb_en = 1'b0;
    if (wr_lo) begin
      tb_d  = {tb_q[TW-1:DW], wdata};
      tb_en = 1'b1;
    end else if (wr_hi) begin
      tb_d  = {wdata, tb_q[DW-1:0]};
      tb_en = 1'b1;
    end else if (tick) begin
      tb_d  = tb_q + {{(TW-1){1'b0}}, 1'b1};
      tb_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_q <= '0;
    end else if (tb_en) begin
      tb_q <= tb_d;
    end
  end
endmodule

// File: rtl/tbd_decrementer.sv
module tbd_decrementer #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          clr,
  output logic [DW-1:0] dec_q,
  output logic          pend_q
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] dec_d;
  logic          dec_en;
  logic          evt;
  logic          pend_d;

  always_comb begin
    dec_d  = dec_q;
    dec_en = 1'b0;
    evt    = 1'b0;
    if (wr) begin
      dec_d  = wdata;
      dec_en = 1'b1;
      evt    = wdata[MSB] & ~dec_q[MSB];
    end else if (tick) begin
      dec_d  = dec_q - {{(DW-1){1'b0}}, 1'b1};
      dec_en = 1'b1;
      evt    = (dec_q == '0);
    end
    pend_d = evt | (pend_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q  <= '1;
      pend_q <= 1'b0;
    end else begin
      if (dec_en) dec_q <= dec_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/tbdec_timer.sv
module tbdec_timer
  import tbd_pkg::*;
#(
  parameter int          DW       = 32,
  parameter logic [31:0] RTC_MASK = 32'h3FFF_FF80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          rtc_mode,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          irq_clr,
  output logic          irq
);
  localparam int TW = 2 * DW;

  logic          rst_s1_n;
  logic          rst_sync_n;
  reg_sel_e      sel;
  logic [DW-1:0] lo_mask;
  logic          wr_lo, wr_hi, wr_dec;
  logic [TW-1:0] tb_cur;
  logic [DW-1:0] dec_cur;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1_n   <= 1'b1;
      rst_sync_n <= rst_s1_n;
    end
  end

  assign sel     = reg_sel_e'(addr);
  assign lo_mask = rtc_mode ? RTC_MASK[DW-1:0] : '1;
  assign wr_lo   = wr_en && (sel == SEL_TB_LO);
  assign wr_hi   = wr_en && (sel == SEL_TB_HI);
  assign wr_dec  = wr_en && (sel == SEL_DEC);

  tbd_timebase #(.DW(DW)) u_tb (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tick  (tick_en),
    .wr_lo (wr_lo),
    .wr_hi (wr_hi),
    .wdata (wr_lo ? (wdata & lo_mask) : wdata),
    .tb_q  (tb_cur)
  );

  tbd_decrementer #(.DW(DW)) u_dec (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick   (tick_en),
    .wr     (wr_dec),
    .wdata  (wdata),
    .clr    (irq_clr),
    .dec_q  (dec_cur),
    .pend_q (irq)
  );

  always_comb begin
    unique case (sel)
      SEL_TB_LO: rdata = tb_cur[DW-1:0] & lo_mask;
      SEL_TB_HI: rdata = tb_cur[TW-1:DW];
      SEL_DEC:   rdata = dec_cur;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/tbdec_checker.sv
module tbdec_checker #(
  parameter int          DW       = 32,
  parameter logic [31:0] RTC_MASK = 32'h3FFF_FF80
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tick_en,
  input logic            rtc_mode,
  input logic            wr_en,
  input logic [1:0]      addr,
  input logic [DW-1:0]   wdata,
  input logic [DW-1:0]   rdata,
  input logic            irq_clr,
  input logic            irq,
  input logic [2*DW-1:0] tb_cur,
  input logic [DW-1:0]   dec_cur
);
  logic dec_w;
  assign dec_w = wr_en && (addr == 2'd2);

  a_r2_tb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !(wr_en && addr[1] == 1'b0)) |=> $stable(tb_cur));

  a_r4_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !dec_w && dec_cur != '0) |=> dec_cur == $past(dec_cur) - 1'b1);

  a_r5_expire_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !dec_w && dec_cur == '0) |=> (dec_cur == '1 && irq));

  a_r6_neg_write: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_w && wdata[DW-1] && !dec_cur[DW-1]) |=> (irq && dec_cur == $past(wdata)));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  a_r9_rtc_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_mode && addr == 2'd0) |-> ((rdata & ~RTC_MASK[DW-1:0]) == '0));

  a_r10_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd3) |-> (rdata == '0));
endmodule

bind tbdec_timer tbdec_checker #(.DW(DW), .RTC_MASK(RTC_MASK)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .tick_en  (tick_en),
  .rtc_mode (rtc_mode),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .irq_clr  (irq_clr),
  .irq      (irq),
  .tb_cur   (tb_cur),
  .dec_cur  (dec_cur)
);

// File: tb/sim_tbdec_timer.sv
module sim_tbdec_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, rtc_mode, wr_en, irq_clr;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [63:0] m_tb;
  logic [31:0] m_dec;
  logic        m_irq;

  always #5 clk = ~clk;

  tbdec_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rtc_mode(rtc_mode),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_clr(irq_clr), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reads all registers within the low phase; rdata is combinational
  task automatic check_all(input string req);
    logic [31:0] msk;
    msk = rtc_mode ? 32'h3FFF_FF80 : 32'hFFFF_FFFF;
    addr = 2'd0; #1 chk(req, rdata, m_tb[31:0] & msk);
    addr = 2'd1; #1 chk(req, rdata, m_tb[63:32]);
    addr = 2'd2; #1 chk(req, rdata, m_dec);
    chk(req, {31'd0, irq}, {31'd0, m_irq});
  endtask

  // one clock: drive at falling edge, apply model, land at next falling edge
  task automatic cyc(input logic tk, input logic wr, input logic [1:0] a,
                     input logic [31:0] wd, input logic clr);
    logic        set;
    logic [31:0] msk;
    msk = rtc_mode ? 32'h3FFF_FF80 : 32'hFFFF_FFFF;
    tick_en = tk; wr_en = wr; addr = a; wdata = wd; irq_clr = clr;
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0; irq_clr = 1'b0;
    set = 1'b0;
    if (wr && a == 2'd2) begin
      set   = wd[31] && !m_dec[31];
      m_dec = wd;
    end else if (tk) begin
      set   = (m_dec == 32'd0);
      m_dec = m_dec - 32'd1;
    end
    if (wr && a == 2'd0)      m_tb[31:0]  = wd & msk;
    else if (wr && a == 2'd1) m_tb[63:32] = wd;
    else if (tk)              m_tb        = m_tb + 64'd1;
    m_irq = set ? 1'b1 : (clr ? 1'b0 : m_irq);
  endtask

  initial begin
    int cnt = 0;
    while (!done) begin
      @(posedge clk);
      cnt++;
      if (cnt > 100000 && !done) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<=100000", cnt);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; rtc_mode = 1'b0; wr_en = 1'b0;
    irq_clr = 1'b0; addr = 2'd0; wdata = '0;
    m_tb = '0; m_dec = 32'hFFFF_FFFF; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1");

    // R2/R4: tick patterns, including idle cycles
    for (int i = 0; i < 40; i++) begin
      cyc(((i % 3) != 1), 1'b0, 2'd0, 32'd0, 1'b0);
      check_all("R2");
    end

    // R2/R3: carry from low word into high word
    cyc(1'b0, 1'b1, 2'd0, 32'hFFFF_FFFE, 1'b0); check_all("R3");
    cyc(1'b1, 1'b0, 2'd0, 32'd0, 1'b0);         check_all("R2");
    cyc(1'b1, 1'b0, 2'd0, 32'd0, 1'b0);         check_all("R2");
    cyc(1'b0, 1'b1, 2'd1, 32'hA5A5_0001, 1'b0); check_all("R3");
    cyc(1'b0, 1'b1, 2'd0, 32'h1234_5678, 1'b0); check_all("R3");

    // R5: run the decrementer through zero
    cyc(1'b0, 1'b1, 2'd2, 32'd3, 1'b0);         check_all("R4");
    for (int i = 0; i < 5; i++) begin
      cyc(1'b1, 1'b0, 2'd0, 32'd0, 1'b0);
      check_all("R5");
    end
    // R7: sticky until cleared, then cleared
    cyc(1'b0, 1'b0, 2'd0, 32'd0, 1'b0);         check_all("R7");
    cyc(1'b0, 1'b0, 2'd0, 32'd0, 1'b1);         check_all("R7");
    // R7: expiry coinciding with clear keeps irq
    cyc(1'b0, 1'b1, 2'd2, 32'd0, 1'b0);         check_all("R7");
    cyc(1'b1, 1'b0, 2'd0, 32'd0, 1'b1);         check_all("R7");
    chk("R7 set beats clear", {31'd0, irq}, 32'd1);
    cyc(1'b0, 1'b0, 2'd0, 32'd0, 1'b1);         check_all("R7");

    // R6: sweep of old/new sign combinations
    for (int o = 0; o < 2; o++) begin
      for (int n = 0; n < 2; n++) begin
        cyc(1'b0, 1'b1, 2'd2, {o[0], 31'h15}, 1'b0);
        cyc(1'b0, 1'b0, 2'd0, 32'd0, 1'b1);
        check_all("R6");
        cyc(1'b0, 1'b1, 2'd2, {n[0], 31'h2A}, 1'b0);
        check_all("R6");
        chk("R6 sign rule", {31'd0, irq}, {31'd0, (n == 1 && o == 0)});
      end
    end
    cyc(1'b0, 1'b0, 2'd0, 32'd0, 1'b1);

    // R8: writes that coincide with a tick
    cyc(1'b0, 1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0);
    cyc(1'b1, 1'b1, 2'd1, 32'h0000_0100, 1'b0); check_all("R8");
    cyc(1'b1, 1'b1, 2'd0, 32'h0000_0040, 1'b0); check_all("R8");
    cyc(1'b1, 1'b1, 2'd2, 32'h0000_0009, 1'b0); check_all("R8");
    cyc(1'b1, 1'b1, 2'd2, 32'h0000_0000, 1'b0); check_all("R8");

    // R10: unused address
    cyc(1'b0, 1'b1, 2'd3, 32'hDEAD_BEEF, 1'b0); check_all("R10");
    addr = 2'd3; #1 chk("R10", rdata, 32'd0);

    // R9: low-word mask in the clock mode
    rtc_mode = 1'b1;
    check_all("R9");
    cyc(1'b0, 1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0); check_all("R9");
    for (int i = 0; i < 200; i++) begin
      cyc(1'b1, 1'b0, 2'd0, 32'd0, 1'b0);
      if (i % 20 == 0) check_all("R9");
    end
    rtc_mode = 1'b0;
    check_all("R9");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule